// File: doc/BRIEF.md
# Bus Transfer Byte Counter and Moved-Address Tracker

This block follows one data transfer on a storage bus. Software loads a 24-bit byte count, one byte lane at a time, through a small register write port. A per-byte strobe from the bus side marks each byte as safely transferred. On each strobe the count drops by one and a 32-bit read-only address rises by one. Speculative or write-ahead fetches never reach this block, so the address always points one past the last byte that actually moved.

Two sticky status flags report the transfer state. One is a done flag, raised whenever the count is zero. The other is a wrap flag, raised when a strobe arrives at a zero count and the counter rolls to all ones. Software clears either flag by writing a one to it in a clear register. An enable register selects which flags can drive the registered interrupt output.

A two-state machine tracks whether the count is empty. The state S_ZERO means the count is zero and S_RUN means it is not. The state moves from S_RUN to S_ZERO on EXHAUST, when a strobe consumes the last byte. It also moves to S_ZERO on CLEAR, which is either the control clear or a load of zero. It moves from S_ZERO to S_RUN on ARM, a non-zero load, or on WRAP, a strobe that arrives at zero. The done flag is set on every cycle that ends in S_ZERO.

Top module: `xfer_count_tracker`

## Requirements
- R1: A write with `reg_sel` 0, 1 or 2 replaces count bits [7:0], [15:8] or [23:16] respectively with `reg_wdata` at that clock edge and leaves the other bytes unchanged. A byte load in the same cycle as `byte_done` takes priority, and the strobe does not decrement the count.
- R2: On each `byte_done` edge with no load or clear and a non-zero count, the count drops by exactly one. Without a strobe, load or clear, the count holds.
- R3: Status bit 0 (done) is 1 on every cycle in which the count is zero, updated at the same edge as the count. It stays set until cleared, and a clear has no effect while the count is zero.
- R4: A `byte_done` strobe at a zero count with no load or clear sets the count to 0xFFFFFF and sets status bit 1 (wrap).
- R5: The moved address resets to 0 and rises by exactly one on every `byte_done` edge. This includes strobes that coincide with a load and strobes that wrap the count. Without a strobe it holds.
- R6: A write with `reg_sel` 4 clears each status bit whose `reg_wdata` bit (bit 0 done, bit 1 wrap) is 1. Zero bits leave the flags unchanged, and a set condition in the same cycle wins over the clear.
- R7: A write with `reg_sel` 5 loads the enable mask from `reg_wdata[1:0]`. `irq` equals the OR of (status AND enable) as it stood one clock earlier.
- R8: A write with `reg_sel` 3 and `reg_wdata[0]`=1 clears the count to zero. With `reg_wdata[0]`=0 the write has no effect.
- R9: After reset the count is 0, the address is 0, status is 2'b01 (done set), the enables are 0 and `irq` is 0.
- R10: Writes with `reg_sel` 6 or 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0-2 count bytes, 3 control, 4 clear, 5 enable) |
| reg_wdata | input | 8 | Register write data |
| byte_done | input | 1 | One byte safely transferred on the bus |
| xfer_count | output | 24 | Remaining byte count |
| moved_addr | output | 32 | Address following the last byte moved |
| status | output | 2 | Bit 0 done, bit 1 wrap |
| irq | output | 1 | Registered interrupt request |

## Verification
The in-line properties check the following on every cycle:
- the single-step decrement and hold of the count;
- the address step and hold;
- the rollover to all ones and the wrap flag that follows it;
- the done flag at every zero count;
- the control clear;
- the one-cycle interrupt relation.

Only the bench's scenarios can show other behaviour:
- byte-lane placement during loads;
- load priority over a coinciding strobe;
- the fact that a clear has no effect while the count stays zero;
- the inertness of unused selects and zero data bits.

A behavioural reference model compares every output on every clock across these scenarios.

// File: rtl/tct_pkg.sv
package tct_pkg;
    localparam int SEL_W  = 3;
    localparam int NSTAT  = 2;
    localparam int ST_DONE = 0;
    localparam int ST_WRAP = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_CNT0 = 3'd0,
        SEL_CNT1 = 3'd1,
        SEL_CNT2 = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_CLR  = 3'd4,
        SEL_EN   = 3'd5
    } reg_sel_e;

    typedef enum logic {
        S_ZERO = 1'b0,
        S_RUN  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8,
    localparam int NLANE = CNT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLANE-1:0]  lane_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr_cnt,
    input  logic              strobe,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              zero_nx,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wrap_evt
);
    logic [CNT_W-1:0] cnt_d;
    logic             any_load;

    assign any_load = |lane_we;

    always_comb begin
        cnt_d    = cnt_q;
        wrap_evt = 1'b0;
        if (any_load) begin
            for (int i = 0; i < NLANE; i++) begin
                if (lane_we[i]) cnt_d[i*BYTE_W +: BYTE_W] = wdata;
            end
        end else if (clr_cnt) begin
            cnt_d = '0;
        end else if (strobe) begin
            if (cnt_q == '0) begin
                cnt_d    = '1;
                wrap_evt = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    assign zero_nx = (cnt_d == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (strobe) addr_q <= addr_q + 1'b1;
        end
    end

    p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !any_load && !clr_cnt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !any_load && !clr_cnt) |=> $stable(cnt_q));
    p_roll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !any_load && !clr_cnt && cnt_q == '0) |=> (&cnt_q));
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (addr_q == $past(addr_q) + 1'b1));
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(addr_q));
endmodule

// File: rtl/tct_status.sv
module tct_status
    import tct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_nx,
    input  logic             wrap_evt,
    input  logic [NSTAT-1:0] clr_mask,
    input  logic             en_we,
    input  logic [NSTAT-1:0] en_data,
    output logic [NSTAT-1:0] stat_q,
    output logic             irq_q
);
    cnt_state_e       st_q, st_d;
    logic [NSTAT-1:0] en_q;

    // next-state: EXHAUST/CLEAR enter S_ZERO, ARM/WRAP enter S_RUN
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_ZERO: if (wrap_evt || !zero_nx) st_d = S_RUN;
            S_RUN:  if (zero_nx)              st_d = S_ZERO;
            default: st_d = S_ZERO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_ZERO;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= NSTAT'(1 << ST_DONE);
            en_q   <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q[ST_DONE] <= (st_d == S_ZERO) | (stat_q[ST_DONE] & ~clr_mask[ST_DONE]);
            stat_q[ST_WRAP] <= wrap_evt | (stat_q[ST_WRAP] & ~clr_mask[ST_WRAP]);
            if (en_we) en_q <= en_data;
            irq_q <= |(stat_q & en_q);
        end
    end

    p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> stat_q[ST_WRAP]);
    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q == $past(|(stat_q & en_q))));
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask[ST_WRAP] && !wrap_evt) |=> !stat_q[ST_WRAP]);
endmodule

// File: rtl/xfer_count_tracker.sv
module xfer_count_tracker
    import tct_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              byte_done,
    output logic [CNT_W-1:0]  xfer_count,
    output logic [ADDR_W-1:0] moved_addr,
    output logic [NSTAT-1:0]  status,
    output logic              irq
);
    localparam int NLANE = CNT_W / BYTE_W;

    logic [NLANE-1:0] lane_we;
    logic             clr_cnt, zero_nx, wrap_evt, en_we;
    logic [NSTAT-1:0] clr_mask;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_we[g] = reg_wr && (reg_sel == SEL_W'(SEL_CNT0 + g));
    end

    assign clr_cnt  = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[0];
    assign clr_mask = (reg_wr && reg_sel == SEL_CLR) ? reg_wdata[NSTAT-1:0] : '0;
    assign en_we    = reg_wr && (reg_sel == SEL_EN);

    tct_counter #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .wdata(reg_wdata),
        .clr_cnt(clr_cnt), .strobe(byte_done), .cnt_q(xfer_count),
        .zero_nx(zero_nx), .addr_q(moved_addr), .wrap_evt(wrap_evt)
    );

    tct_status u_status (
        .clk(clk), .rst_n(rst_n), .zero_nx(zero_nx), .wrap_evt(wrap_evt),
        .clr_mask(clr_mask), .en_we(en_we), .en_data(reg_wdata[NSTAT-1:0]),
        .stat_q(status), .irq_q(irq)
    );

    p_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_count == '0) |-> status[ST_DONE]);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CTRL && reg_wdata[0]) |=> (xfer_count == '0));
endmodule

// File: tb/test_xfer_count_tracker.sv
`timescale 1ns/1ps
module test_xfer_count_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        byte_done = 1'b0;
    logic [23:0] xfer_count;
    logic [31:0] moved_addr;
    logic [1:0]  status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R9";

    // reference model state
    logic [23:0] m_cnt = '0;
    logic [31:0] m_addr = '0;
    logic        m_done = 1'b1, m_wrap = 1'b0, m_irq = 1'b0;
    logic [1:0]  m_en = '0;

    always #2.5 clk = ~clk;

    xfer_count_tracker i_xfer_count_tracker (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .byte_done(byte_done), .xfer_count(xfer_count),
        .moved_addr(moved_addr), .status(status), .irq(irq)
    );

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("count", {8'd0, xfer_count}, {8'd0, m_cnt});
        chk("address", moved_addr, m_addr);
        chk("status", {30'd0, status}, {30'd0, m_wrap, m_done});
        chk("irq", {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic model_edge(bit wr, logic [2:0] sel, logic [7:0] d, bit stb);
        logic wrapev;
        logic [1:0] w1c;
        logic irq_n;
        wrapev = 1'b0;
        irq_n = |({m_wrap, m_done} & m_en);
        w1c = (wr && sel == 3'd4) ? d[1:0] : 2'b00;
        if (wr && sel <= 3'd2) begin
            case (sel)
                3'd0: m_cnt[7:0]   = d;
                3'd1: m_cnt[15:8]  = d;
                default: m_cnt[23:16] = d;
            endcase
        end else if (wr && sel == 3'd3 && d[0]) begin
            m_cnt = '0;
        end else if (stb) begin
            if (m_cnt == 0) begin m_cnt = 24'hFFFFFF; wrapev = 1'b1; end
            else m_cnt = m_cnt - 1;
        end
        if (stb) m_addr = m_addr + 1;
        m_done = (m_cnt == 0) | (m_done & ~w1c[0]);
        m_wrap = wrapev | (m_wrap & ~w1c[1]);
        if (wr && sel == 3'd5) m_en = d[1:0];
        m_irq = irq_n;
    endtask

    task automatic step(bit wr, logic [2:0] sel, logic [7:0] d, bit stb);
        @(negedge clk);
        reg_wr = wr; reg_sel = sel; reg_wdata = d; byte_done = stb;
        @(posedge clk);
        model_edge(wr, sel, d, stb);
        #1;
        compare_all();
    endtask

    task automatic wr_reg(logic [2:0] sel, logic [7:0] d);
        step(1'b1, sel, d, 1'b0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'd0, 1'b0);
    endtask

    task automatic strobes(int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'd0, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R9";
        compare_all();
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        cur_req = "R1";
        wr_reg(3'd0, 8'h03);
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd2, 8'h00);
        cur_req = "R7";
        wr_reg(3'd5, 8'h03);
        idle(2);
        cur_req = "R6";
        wr_reg(3'd4, 8'h01);
        idle(2);
        cur_req = "R2";
        strobes(2);
        cur_req = "R3";
        strobes(1);
        idle(2);
        wr_reg(3'd4, 8'h01);
        idle(1);
        cur_req = "R4";
        strobes(1);
        idle(2);
        cur_req = "R6";
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd4, 8'h02);
        idle(2);
        cur_req = "R8";
        wr_reg(3'd3, 8'hFE);
        idle(1);
        wr_reg(3'd3, 8'h01);
        idle(1);
        cur_req = "R1";
        wr_reg(3'd2, 8'hA5);
        wr_reg(3'd1, 8'h5A);
        step(1'b1, 3'd0, 8'h10, 1'b1);
        cur_req = "R5";
        strobes(5);
        step(1'b0, 3'd0, 8'd0, 1'b0);
        strobes(3);
        cur_req = "R10";
        wr_reg(3'd6, 8'hFF);
        wr_reg(3'd7, 8'hFF);
        idle(1);
        cur_req = "R7";
        wr_reg(3'd5, 8'h02);
        wr_reg(3'd0, 8'h01);
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd2, 8'h00);
        strobes(2);
        idle(2);
        wr_reg(3'd4, 8'h03);
        idle(2);
        cur_req = "R3";
        wr_reg(3'd0, 8'h02);
        wr_reg(3'd0, 8'h00);
        idle(2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule